// File: doc/BRIEF.md
# Protected Fuse-Word Access Controller

This block sits in front of a small one-time-programmable fuse array and exposes it on a 32-bit register bus. The bus has a byte address, a write enable, write data and read data. Reads are combinational, and writes take effect at the rising clock edge. Any fuse word can be read directly through a read-only window. Protected access goes through three registers instead: a command register, a key register that holds the data to be programmed, and a read-back register that returns the result of a protected read.

A command is started by writing the command register. The write carries the target word index, a magic lock byte and exactly one of two command bits, one for read and one for program. The fuse storage then runs the operation over a fixed number of cycles, `ACC_LAT`. While the operation runs, the matching command bit reads back as 1, and it clears by itself when the operation finishes, so software polls for it.

A program operation ORs the key captured at the start into the addressed word, so fuse bits can only go from 0 to 1. A read operation loads the addressed word into the read-back register when it completes. The fuse storage is modelled as a register array, and it is blank (all zero) after reset.

Top module: `fuse_guard_ctrl`

## Requirements
- R1: After reset, the command register reads 0, the key and read-back registers read 0, and every window word reads 0.
- R2: A write to byte address 0x040 starts a command when all of the following hold: bits 15:8 equal 0xAC, exactly one of bit 1 (read) and bit 0 (program) is set, and no command is running. Bits 23:16 give the target word index. On a command register read, bits 23:16 return the index of the last accepted command, bit 1 shows a read in progress, bit 0 shows a program in progress, and all other bits are 0.
- R3: The read bit reads 1 for exactly `ACC_LAT` cycles after the accepting edge and then clears. From that point the read-back register (address 0x060) holds the addressed fuse word, with its byte 0 in bits 7:0.
- R4: A program operation ORs the key value present when the command was accepted into the addressed word, so no fuse bit ever goes from 1 to 0. The program bit reads 1 for exactly `ACC_LAT` cycles and then clears.
- R5: A command register write is ignored, with no operation started and the readable state unchanged, in three cases: the lock byte is not 0xAC, both command bits are set, or neither command bit is set.
- R6: A command register write while a command is running is ignored. The index and the operation in progress are kept.
- R7: The read-back register keeps its value until the next protected read completes. A program operation, and a read that is still running, leave it unchanged.
- R8: A read at byte address 0x200 + 4*i returns fuse word i for i < `FUSE_WORDS`. Window slots with i >= `FUSE_WORDS`, up to address 0x3FC, read 0.
- R9: A protected command whose index is >= `FUSE_WORDS` still takes `ACC_LAT` cycles. A read of that kind returns 0 and a program of that kind changes no fuse word.
- R10: The key register (address 0x050) reads back the last value written to it. Unmapped addresses read 0, and address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The protected path is exercised with keys that overlap and keys that are disjoint. This shows whether programming ORs into the word or overwrites it. Command writes are also sent with a wrong lock byte, with both command bits set and with neither set, and these separate real acceptance from a simple address match. Commands are aimed at the last implemented word, at an index beyond the depth and at a word while another command is running, which exposes off-by-one depth checks and a missing busy gate. The command bits are polled each cycle to measure the operation length, and the read-back register is sampled during and after each operation to tell holding apart from early update.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h040;
    localparam logic [ADDR_W-1:0] KEY_ADDR  = 12'h050;
    localparam logic [ADDR_W-1:0] RDBK_ADDR = 12'h060;
    localparam logic [2:0]        WIN_TAG   = 3'b001;  // addresses 0x200..0x3FF

    localparam logic [7:0] LOCK_CODE = 8'hAC;

    typedef struct packed {
        logic       go;
        logic       is_rd;
        logic [7:0] idx;
    } fgc_cmd_t;
endpackage

// File: rtl/fgc_cmd_decode.sv
module fgc_cmd_decode
    import fgc_pkg::*;
(
    input  logic              wr_ctrl,
    input  logic              busy,
    input  logic [DATA_W-1:0] wdata,
    output fgc_cmd_t          cmd
);
    logic lock_ok;
    logic one_cmd;
    logic unused_bits;

    assign unused_bits = ^{wdata[31:24], wdata[7:2]};

    always_comb begin
        lock_ok   = (wdata[15:8] == LOCK_CODE);
        one_cmd   = wdata[1] ^ wdata[0];
        cmd.go    = wr_ctrl && !busy && lock_ok && one_cmd;
        cmd.is_rd = wdata[1];
        cmd.idx   = wdata[23:16];
    end
endmodule

// File: rtl/fgc_fuse_array.sv
module fgc_fuse_array
    import fgc_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    parameter int unsigned LAT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fgc_cmd_t          cmd,
    input  logic [DATA_W-1:0] key,
    input  logic [7:0]        win_idx,
    output logic [DATA_W-1:0] win_word,
    output logic              rd_busy,
    output logic              pg_busy,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_word
);
    localparam int unsigned       CNT_W     = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0]  CNT_START = CNT_W'(LAT - 1);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
        logic                         op_rd;
        logic                         op_pg;
        logic [7:0]                   idx;
        logic [DATA_W-1:0]            key;
        logic [CNT_W-1:0]             cnt;
    } st_t;

    st_t st_d, st_q;
    logic busy;
    logic finish;

    assign busy    = st_q.op_rd | st_q.op_pg;
    assign finish  = busy && (st_q.cnt == '0);
    assign rd_busy = st_q.op_rd;
    assign pg_busy = st_q.op_pg;
    assign rd_done = finish && st_q.op_rd;

    always_comb begin
        rd_word  = '0;
        win_word = '0;
        for (int i = 0; i < int'(WORDS); i++) begin
            if (st_q.idx == 8'(i)) rd_word  = st_q.mem[i];
            if (win_idx  == 8'(i)) win_word = st_q.mem[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (busy) begin
            if (finish) begin
                if (st_q.op_pg) begin
                    for (int i = 0; i < int'(WORDS); i++) begin
                        if (st_q.idx == 8'(i)) st_d.mem[i] = st_q.mem[i] | st_q.key;
                    end
                end
                st_d.op_rd = 1'b0;
                st_d.op_pg = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (cmd.go) begin
            st_d.op_rd = cmd.is_rd;
            st_d.op_pg = !cmd.is_rd;
            st_d.idx   = cmd.idx;
            st_d.key   = key;
            st_d.cnt   = CNT_START;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.op_rd, st_q.op_pg}));

    // R3
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.go && cmd.is_rd) |=> rd_busy);

    // R4
    for (genvar g = 0; g < int'(WORDS); g++) begin : g_mono
        fuse_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_q.mem[g]) & ~st_q.mem[g]) == '0);
    end
endmodule

// File: rtl/fuse_guard_ctrl.sv
module fuse_guard_ctrl
    import fgc_pkg::*;
#(
    parameter int unsigned FUSE_WORDS = 16,
    parameter int unsigned ACC_LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int unsigned WA_W = ADDR_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] key;
        logic [7:0]        idx;
        logic [DATA_W-1:0] rdbk;
    } regs_t;

    regs_t r_d, r_q;

    logic [WA_W-1:0]   wa;
    logic              hit_ctrl, hit_key, hit_rdbk, hit_win;
    logic [7:0]        win_idx;
    logic [DATA_W-1:0] win_word, rd_word;
    logic              rd_busy, pg_busy, rd_done;
    fgc_cmd_t          cmd;
    logic              unused_addr;

    assign unused_addr = ^bus_addr[1:0];
    assign wa       = bus_addr[ADDR_W-1:2];
    assign hit_ctrl = (wa == CTRL_ADDR[ADDR_W-1:2]);
    assign hit_key  = (wa == KEY_ADDR[ADDR_W-1:2]);
    assign hit_rdbk = (wa == RDBK_ADDR[ADDR_W-1:2]);
    assign hit_win  = (bus_addr[ADDR_W-1:9] == WIN_TAG);
    assign win_idx  = {1'b0, bus_addr[8:2]};

    fgc_cmd_decode u_dec (
        .wr_ctrl (bus_we && hit_ctrl),
        .busy    (rd_busy || pg_busy),
        .wdata   (bus_wdata),
        .cmd     (cmd)
    );

    fgc_fuse_array #(.WORDS(FUSE_WORDS), .LAT(ACC_LAT)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .key      (r_q.key),
        .win_idx  (win_idx),
        .win_word (win_word),
        .rd_busy  (rd_busy),
        .pg_busy  (pg_busy),
        .rd_done  (rd_done),
        .rd_word  (rd_word)
    );

    always_comb begin
        r_d = r_q;
        if (bus_we && hit_key) r_d.key  = bus_wdata;
        if (cmd.go)            r_d.idx  = cmd.idx;
        if (rd_done)           r_d.rdbk = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata = {8'h00, r_q.idx, 8'h00, 6'b0, rd_busy, pg_busy};
        else if (hit_key)  bus_rdata = r_q.key;
        else if (hit_rdbk) bus_rdata = r_q.rdbk;
        else if (hit_win)  bus_rdata = win_word;
    end

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_busy || pg_busy) && bus_we && hit_ctrl) |=> $stable(r_q.idx));

    // R5
    bad_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_busy || pg_busy) && bus_we && hit_ctrl && bus_wdata[15:8] != LOCK_CODE)
        |=> !(rd_busy || pg_busy));

    // R7
    rdbk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.rdbk) |-> $past(rd_done));
endmodule

// File: tb/fuse_guard_ctrl_bench.sv
module fuse_guard_ctrl_bench;
    localparam int WORDS = 16;
    localparam int LAT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_mem [WORDS];
    logic [31:0] exp_rdbk = '0;

    always #2.5 clk = ~clk;

    fuse_guard_ctrl #(.FUSE_WORDS(WORDS), .ACC_LAT(LAT)) u_fuse_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [7:0] idx, input logic [7:0] lock, input logic [1:0] ops);
        return {8'h00, idx, lock, 6'b0, ops};
    endfunction

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            rd(12'h040, v);
            if (v[1:0] == 2'b00) break;
            n++;
        end
    endtask

    task automatic prog(input int idx, input logic [31:0] key, input string req);
        int n;
        wr(12'h050, key);
        wr(12'h040, ctrl_word(8'(idx), 8'hAC, 2'b01));
        wait_idle(n);
        check(n == LAT, req, 32'(n), 32'(LAT));
        if (idx < WORDS) exp_mem[idx] = exp_mem[idx] | key;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h040, v); check(v == 0, "R1 ctrl", v, 0);
        rd(12'h050, v); check(v == 0, "R1 key", v, 0);
        rd(12'h060, v); check(v == 0, "R1 rdbk", v, 0);
        rd(12'h200, v); check(v == 0, "R1 win0", v, 0);
        rd(12'h23C, v); check(v == 0, "R1 win15", v, 0);
    endtask

    task automatic t_program;
        logic [31:0] v;
        prog(3, 32'h0000_00F1, "R4 prog busy length");
        rd(12'h20C, v); check(v == 32'h0000_00F1, "R4 R8 first program", v, 32'h0000_00F1);
        prog(3, 32'h0F00_0302, "R4 prog busy length 2");
        rd(12'h20C, v); check(v == 32'h0F00_03F3, "R4 OR merge", v, 32'h0F00_03F3);
        rd(12'h040, v); check(v == 32'h0003_0000, "R2 ctrl idx field", v, 32'h0003_0000);
    endtask

    task automatic t_read;
        logic [31:0] v;
        int n;
        wr(12'h040, ctrl_word(8'd3, 8'hAC, 2'b10));
        rd(12'h040, v); check(v == 32'h0003_0002, "R2 R3 read bit set", v, 32'h0003_0002);
        rd(12'h060, v); check(v == exp_rdbk, "R7 rdbk during read", v, exp_rdbk);
        wait_idle(n);
        check(n == LAT - 2, "R3 read busy length", 32'(n + 2), 32'(LAT));
        exp_rdbk = exp_mem[3];
        rd(12'h060, v); check(v == exp_rdbk, "R3 rdbk value", v, exp_rdbk);
        check(v[7:0] == 8'hF3, "R3 byte0 in bits 7:0", {24'b0, v[7:0]}, 32'hF3);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        prog(7, 32'h1234_0000, "R4 prog word7");
        rd(12'h060, v); check(v == exp_rdbk, "R7 rdbk after program", v, exp_rdbk);
    endtask

    task automatic t_bad_ctrl;
        logic [31:0] v;
        wr(12'h040, ctrl_word(8'd2, 8'hAB, 2'b10));
        rd(12'h040, v); check(v == 32'h0007_0000, "R5 wrong lock", v, 32'h0007_0000);
        wr(12'h040, ctrl_word(8'd2, 8'hAC, 2'b11));
        rd(12'h040, v); check(v == 32'h0007_0000, "R5 both bits", v, 32'h0007_0000);
        wr(12'h040, ctrl_word(8'd2, 8'hAC, 2'b00));
        rd(12'h040, v); check(v == 32'h0007_0000, "R5 no bit", v, 32'h0007_0000);
        rd(12'h060, v); check(v == exp_rdbk, "R5 rdbk untouched", v, exp_rdbk);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        int n;
        prog(1, 32'hA5A5_0001, "R4 prog word1");
        wr(12'h050, 32'hFFFF_FFFF);
        wr(12'h040, ctrl_word(8'd1, 8'hAC, 2'b10));
        wr(12'h040, ctrl_word(8'd9, 8'hAC, 2'b01));
        rd(12'h040, v); check(v == 32'h0001_0002, "R6 ctrl kept while busy", v, 32'h0001_0002);
        wait_idle(n);
        rd(12'h224, v); check(v == exp_mem[9], "R6 word9 untouched", v, exp_mem[9]);
        exp_rdbk = exp_mem[1];
        rd(12'h060, v); check(v == exp_rdbk, "R6 R3 read result", v, exp_rdbk);
    endtask

    task automatic t_window;
        logic [31:0] v;
        prog(15, 32'h8000_0001, "R4 prog last word");
        rd(12'h23C, v); check(v == 32'h8000_0001, "R8 last word", v, 32'h8000_0001);
        rd(12'h250, v); check(v == 0, "R8 slot 20 beyond depth", v, 0);
        rd(12'h3FC, v); check(v == 0, "R8 slot 127", v, 0);
        rd(12'h20E, v); check(v == exp_mem[3], "R10 R8 low addr bits ignored", v, exp_mem[3]);
    endtask

    task automatic t_prot_oob;
        logic [31:0] v;
        bit same = 1'b1;
        int n;
        prog(40, 32'hFFFF_FFFF, "R9 oob program length");
        for (int i = 0; i < WORDS; i++) begin
            rd(12'h200 + 12'(4 * i), v);
            if (v != exp_mem[i]) same = 1'b0;
        end
        check(same, "R9 oob program changes nothing", {31'b0, same}, 1);
        wr(12'h040, ctrl_word(8'd40, 8'hAC, 2'b10));
        wait_idle(n);
        check(n == LAT, "R9 oob read length", 32'(n), 32'(LAT));
        exp_rdbk = 0;
        rd(12'h060, v); check(v == 0, "R9 oob read returns zero", v, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(12'h050, 32'hDEAD_BEEF);
        rd(12'h050, v); check(v == 32'hDEAD_BEEF, "R10 key readback", v, 32'hDEAD_BEEF);
        rd(12'h044, v); check(v == 0, "R10 unmapped 0x044", v, 0);
        rd(12'h100, v); check(v == 0, "R10 unmapped 0x100", v, 0);
        rd(12'h064, v); check(v == 0, "R10 unmapped 0x064", v, 0);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_program();
        t_read();
        t_hold();
        t_bad_ctrl();
        t_busy_ignore();
        t_window();
        t_prot_oob();
        t_regs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule